// File: doc/BRIEF.md
# Key-Protected Register Bank Lock

This block is a small bank of 32-bit control registers on a simple register bus. The bus has an address, a write strobe with write data, and a read strobe with registered read data. The control registers accept a write only while the bank is unlocked. The bank is unlocked by writing a fixed 32-bit magic word into protection registers.

There are two protection registers, and the coupling between them is one-way:

- A write to the primary protection register sets the lock state of both protection registers.
- A write to the secondary protection register affects the secondary alone.
- Protected writes go through only while both protection registers report unlocked.

Each protection register reads back as a single state bit: 1 means unlocked and 0 means locked. Software can therefore re-arm the bank with one write to the primary, or partially lock it through the secondary.

Top module: `keylock_regbank`

## Requirements
- R1: After reset, both protection registers read 0 (locked), every control register reads 0x00000000, and rd_data is 0x00000000.
- R2: Writing 0x1688A8A8 to the primary protection register (offset 0x000) makes both the primary and the secondary (offset 0x010) read 0x00000001.
- R3: Writing any other value to the primary protection register makes both protection registers read 0x00000000. This includes a value that differs from the key in one bit, and it applies whatever the current state is.
- R4: A write to the secondary protection register sets only the secondary: the key gives 1 and any other value gives 0. The primary keeps its state.
- R5: A write to a control register (offset 0x0C4 + 4*i, for i below N_CTRL) is stored only while both protection registers read 1. Otherwise the write is dropped and the register keeps its old value.
- R6: A new lock state applies to bus writes from the cycle after the protection write. A control write issued in the very next cycle after an unlocking key write is stored.
- R7: A read of an offset that holds no register returns 0x00000000. This includes unaligned offsets. A write to such an offset changes no register.
- R8: rd_data shows the addressed register one clock after the cycle in which rd_en is high, using the state from before that edge. In cycles without rd_en, rd_data holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW (12) | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW (32) | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW (32) | Registered read data |

## Verification
A write changes state at the edge that samples it, so a register written in one cycle is visible to a read issued in the next cycle. The read data then appears one further edge later.

The bench drives inputs on the falling edge. Its behavioural model updates on the rising edge, and the model's expected read data is compared with rd_data on every falling edge. Each directed read is checked on the falling edge right after the rising edge that captured it. The lock-timing case places a control write in the cycle directly after the key write, so any extra delay in the lock path makes that write get dropped.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  localparam logic [31:0] UNLOCK_KEY = 32'h1688_A8A8;
  localparam int unsigned PRIM_OFFSET = 'h000;
  localparam int unsigned SEC_OFFSET  = 'h010;
  localparam int unsigned CTRL_BASE   = 'h0C4;

  typedef struct packed {
    logic prim;
    logic sec;
  } lock_state_t;
endpackage

// File: rtl/keylock_guard.sv
module keylock_guard
  import keylock_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output lock_state_t   state_q
);
  localparam logic [AW-1:0] PRIM_A = AW'(PRIM_OFFSET);
  localparam logic [AW-1:0] SEC_A  = AW'(SEC_OFFSET);

  logic        hit_prim, hit_sec, key_ok;
  logic        prim_en, sec_en;
  lock_state_t state_d;

  always_comb begin
    hit_prim = wr_en && (addr == PRIM_A);
    hit_sec  = wr_en && (addr == SEC_A);
    key_ok   = (wr_data == DW'(UNLOCK_KEY));
    // The primary drives both bits; the secondary drives only its own bit.
    prim_en  = hit_prim;
    sec_en   = hit_prim || hit_sec;
    state_d  = state_q;
    if (prim_en) state_d.prim = key_ok;
    if (sec_en)  state_d.sec  = key_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (sec_en) begin
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/keylock_ctrl_regs.sv
module keylock_ctrl_regs
  import keylock_pkg::*;
#(
  parameter int unsigned AW     = 12,
  parameter int unsigned DW     = 32,
  parameter int unsigned N_CTRL = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       wr_allow,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wr_data,
  output logic [N_CTRL-1:0][DW-1:0]  regs_q,
  output logic [N_CTRL-1:0]          reg_we
);
  for (genvar i = 0; i < N_CTRL; i++) begin : g_reg
    localparam logic [AW-1:0] OFF = AW'(CTRL_BASE + 4 * i);
    logic [DW-1:0] d;

    always_comb begin
      reg_we[i] = wr_en && wr_allow && (addr == OFF);
      d         = reg_we[i] ? wr_data : regs_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[i] <= '0;
      end else if (reg_we[i]) begin
        regs_q[i] <= d;
      end
    end
  end
endmodule

// File: rtl/keylock_rdmux.sv
module keylock_rdmux
  import keylock_pkg::*;
#(
  parameter int unsigned AW     = 12,
  parameter int unsigned DW     = 32,
  parameter int unsigned N_CTRL = 4
) (
  input  logic [AW-1:0]             addr,
  input  lock_state_t               state,
  input  logic [N_CTRL-1:0][DW-1:0] regs,
  output logic [DW-1:0]             word
);
  always_comb begin
    word = '0;
    if (addr == AW'(PRIM_OFFSET)) word = DW'(state.prim);
    if (addr == AW'(SEC_OFFSET))  word = DW'(state.sec);
    for (int i = 0; i < N_CTRL; i++) begin
      if (addr == AW'(CTRL_BASE + 4 * i)) word = regs[i];
    end
  end
endmodule

// File: rtl/keylock_regbank.sv
module keylock_regbank
  import keylock_pkg::*;
#(
  parameter int unsigned AW     = 12,
  parameter int unsigned DW     = 32,
  parameter int unsigned N_CTRL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data
);
  lock_state_t               lock_q;
  logic                      prim_unl, sec_unl, wr_allow;
  logic [N_CTRL-1:0][DW-1:0] ctrl_q;
  logic [N_CTRL-1:0]         ctrl_we;
  logic [DW-1:0]             rd_word, rd_d;

  keylock_guard #(.AW(AW), .DW(DW)) guard_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .state_q (lock_q)
  );

  assign prim_unl = lock_q.prim;
  assign sec_unl  = lock_q.sec;
  assign wr_allow = prim_unl && sec_unl;

  keylock_ctrl_regs #(.AW(AW), .DW(DW), .N_CTRL(N_CTRL)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_allow (wr_allow),
    .addr     (addr),
    .wr_data  (wr_data),
    .regs_q   (ctrl_q),
    .reg_we   (ctrl_we)
  );

  keylock_rdmux #(.AW(AW), .DW(DW), .N_CTRL(N_CTRL)) rdmux_i (
    .addr  (addr),
    .state (lock_q),
    .regs  (ctrl_q),
    .word  (rd_word)
  );

  always_comb rd_d = rd_en ? rd_word : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_d;
    end
  end
endmodule

// File: rtl/keylock_regbank_chk.sv
module keylock_regbank_chk
  import keylock_pkg::*;
#(
  parameter int unsigned AW     = 12,
  parameter int unsigned DW     = 32,
  parameter int unsigned N_CTRL = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     addr,
  input logic              wr_en,
  input logic [DW-1:0]     wr_data,
  input logic              rd_en,
  input logic [DW-1:0]     rd_data,
  input logic              prim_unl,
  input logic              sec_unl,
  input logic [N_CTRL-1:0] ctrl_we
);
  function automatic logic is_mapped(input logic [AW-1:0] a);
    logic m;
    m = (a == AW'(PRIM_OFFSET)) || (a == AW'(SEC_OFFSET));
    for (int i = 0; i < N_CTRL; i++) m = m || (a == AW'(CTRL_BASE + 4 * i));
    return m;
  endfunction

  logic prim_wr, sec_wr, key_ok;
  assign prim_wr = wr_en && (addr == AW'(PRIM_OFFSET));
  assign sec_wr  = wr_en && (addr == AW'(SEC_OFFSET));
  assign key_ok  = (wr_data == DW'(UNLOCK_KEY));

  a_r2_key_unlocks_both: assert property (@(posedge clk) disable iff (!rst_n)
    prim_wr && key_ok |=> prim_unl && sec_unl);

  a_r3_other_locks_both: assert property (@(posedge clk) disable iff (!rst_n)
    prim_wr && !key_ok |=> !prim_unl && !sec_unl);

  a_r4_sec_leaves_prim: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr |=> $stable(prim_unl) && (sec_unl == $past(key_ok)));

  a_r5_write_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (|ctrl_we) |-> prim_unl && sec_unl);

  a_r5_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl_we));

  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !is_mapped(addr) |=> rd_data == '0);

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind keylock_regbank keylock_regbank_chk #(.AW(AW), .DW(DW), .N_CTRL(N_CTRL)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .prim_unl (prim_unl),
  .sec_unl  (sec_unl),
  .ctrl_we  (ctrl_we)
);

// File: tb/keylock_regbank_tb_top.sv
module keylock_regbank_tb_top;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int N  = 4;
  localparam logic [31:0] KEY = 32'h1688_A8A8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #10 clk = ~clk; // 50 MHz

  keylock_regbank #(.AW(AW), .DW(DW), .N_CTRL(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
  );

  // Behavioural reference model
  bit          m_prim, m_sec;
  logic [31:0] m_ctrl [int];
  logic [31:0] m_rd;

  function automatic logic [31:0] m_read(int a);
    if (a == 'h000) return {31'b0, m_prim};
    if (a == 'h010) return {31'b0, m_sec};
    if (m_ctrl.exists(a)) return m_ctrl[a];
    return 32'h0;
  endfunction

  task automatic m_reset();
    m_prim = 0; m_sec = 0; m_rd = 0;
    m_ctrl.delete();
    for (int i = 0; i < N; i++) m_ctrl['h0C4 + 4 * i] = 32'h0;
  endtask

  initial m_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reset();
    end else begin
      int a;
      a = int'(addr);
      if (rd_en) m_rd = m_read(a);
      if (wr_en) begin
        if (a == 'h000) begin
          m_prim = (wr_data == KEY);
          m_sec  = (wr_data == KEY);
        end else if (a == 'h010) begin
          m_sec = (wr_data == KEY);
        end else if (m_ctrl.exists(a) && m_prim && m_sec) begin
          m_ctrl[a] = wr_data;
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Every-cycle comparison against the model (R8 timing and holding)
  always @(negedge clk) begin
    if (rst_n && !done) chk("R8 model", rd_data, m_rd);
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
  endtask

  task automatic rd(string req, int a, logic [31:0] exp);
    @(negedge clk);
    addr = AW'(a); wr_en = 1'b0; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rd_data, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd_data in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    rd("R1 prim", 'h000, 0);
    rd("R1 sec",  'h010, 0);
    rd("R1 ctrl0", 'h0C4, 0);
    rd("R1 ctrl3", 'h0D0, 0);

    wr('h0C4, 32'hABCD_EFAB);
    rd("R5 locked drop", 'h0C4, 0);

    wr('h000, 32'h1688_A8A9);
    rd("R3 near key", 'h000, 0);

    wr('h000, KEY);
    rd("R2 prim", 'h000, 1);
    rd("R2 sec",  'h010, 1);

    wr('h000, 32'h2);
    wr('h000, KEY);
    wr('h0C8, 32'h1234_5678);   // directly after the key write
    rd("R6 next-cycle write", 'h0C8, 32'h1234_5678);

    wr('h0C4, 32'hABCD_EFAB);
    rd("R5 unlocked store", 'h0C4, 32'hABCD_EFAB);

    wr('h010, 32'h2);
    rd("R4 sec locked", 'h010, 0);
    rd("R4 prim kept",  'h000, 1);
    wr('h0CC, 32'h55);
    rd("R5 sec locked drop", 'h0CC, 0);

    wr('h010, KEY);
    rd("R4 sec unlocked", 'h010, 1);
    wr('h0CC, 32'h55);
    rd("R5 both unlocked", 'h0CC, 32'h55);

    wr('h004, 32'hFFFF_FFFF);
    wr('h0C6, 32'hFFFF_FFFF);
    rd("R7 unmapped read", 'h004, 0);
    rd("R7 unaligned read", 'h0C6, 0);
    rd("R7 ctrl0 untouched", 'h0C4, 32'hABCD_EFAB);
    rd("R7 ctrl2 untouched", 'h0CC, 32'h55);
    rd("R7 ctrl3 untouched", 'h0D0, 0);

    wr('h000, 32'h2);
    rd("R3 prim relock", 'h000, 0);
    rd("R3 sec relock",  'h010, 0);
    wr('h0C4, 32'h1111);
    rd("R5 relocked drop", 'h0C4, 32'hABCD_EFAB);

    wr('h010, KEY);
    rd("R4 sec alone", 'h010, 1);
    rd("R4 prim still locked", 'h000, 0);
    wr('h0D0, 32'h77);
    rd("R5 prim locked drop", 'h0D0, 0);

    rd("R8 latch", 'h0C8, 32'h1234_5678);
    idle(4);
    chk("R8 hold", rd_data, 32'h1234_5678);

    finish_run();
  end
endmodule